// File: doc/BRIEF.md
# Dual-Stage Sample Gate with Stale-Sample Drop

This block sits on the receive side of a radio unit, between the packet unpacker and the converter that puts samples on the air. Each lane carries one component (I or Q) of one antenna-carrier, so two carriers need four lanes. A lane holds two FIFOs in series. The first one collects samples as they arrive from the fronthaul. The second one hands them across to the converter clock. A controller in the internal clock domain sits between the two FIFOs. Each time a trigger pulse arrives, it lets a fixed quota of samples per lane cross from the first stage into the second.

The controller counts the samples that cross. If a new trigger arrives before the previous quota has finished crossing, the samples still owed are late. The controller takes that many samples off the head of every first-stage FIFO and discards them, and only then starts the new quota. This restores alignment at each trigger. The second stage is only filled up to a small limit. Surplus samples therefore wait in the first stage, where they can still be dropped. Right after reset, a configurable number of backup samples crosses without any trigger. These backup samples are never dropped.

The unpacker side is a valid/ready stream for each lane. A sample is accepted on a rising `clk` edge where both `in_valid` and `in_ready` are high. `in_ready` goes low while that lane's first stage is full, and the source must then hold its sample. The converter side has no back-pressure. Each `dac_rd` pulse takes one sample. If the second stage is empty at that moment, the read returns zero and the underrun is reported back in the internal domain. An underrun is tolerated; nothing tries to prevent it.

Top module: `dual_stage_gate`

## Requirements
- R1: Each lane's first stage accepts a sample on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while that lane already holds S1_DEPTH samples.
- R2: After reset and before the first trigger, exactly BACKUP samples per lane (the oldest ones) cross to the second stage, and no more.
- R3: After every trigger, exactly QUOTA samples per lane cross. For the first trigger, this comes on top of any backup samples not yet moved. All lanes move in lockstep: one sample from every lane per move, and only when every first stage is non-empty and every second stage has room.
- R4: A sample is written into a lane's second stage only while that stage's occupancy, as seen from the internal domain, is below FILL_LIMIT.
- R5: A trigger, other than the first, that arrives while k samples of the previous quota are still owed causes the next k samples of every lane to be discarded before the new quota moves. `drop_count` then rises by k, counting one per lockstep group. A trigger that arrives after a complete quota drops nothing.
- R6: Within a lane, samples reach `dac_data` in arrival order, with no duplicates. Only the samples that R5 drops are missing.
- R7: A `dac_rd` pulse on an empty second stage loads zero into `dac_data`. It also produces exactly one single-cycle `underrun` pulse for that lane on `clk`, within four `clk` cycles.
- R8: After reset, `in_ready` is high on every lane, `dac_data` is zero, `drop_count` is zero and `underrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset, internal domain |
| in_valid | input | LANES | Per-lane sample valid from the unpacker |
| in_ready | output | LANES | Per-lane ready; low when the first stage is full |
| in_data | input | LANES*W | Per-lane sample, lane l at bits [l*W +: W] |
| trig | input | 1 | One-cycle trigger that opens a new quota |
| drop_count | output | CNT_W | Running count of dropped lockstep groups |
| underrun | output | LANES | One-cycle pulse per empty read, on clk |
| dac_clk | input | 1 | Converter clock |
| dac_rst_n | input | 1 | Active-low reset, converter domain |
| dac_rd | input | LANES | Per-lane read strobe, converter domain |
| dac_data | output | LANES*W | Per-lane registered sample, zero on underrun |

## Verification
A quota counter that is wrong by even one shows up on the converter side. A non-zero sample appears where the bench expects an underrun zero, or a zero appears where it expects the next sample. This becomes visible on the read right after the quota should have ended. A bad drop decision has two signatures. The sample sequence skips or repeats values on the first read after the next trigger, and `drop_count` disagrees within a few cycles of that trigger. A fill limit set too high lets extra samples into the second stage before a late trigger arrives. The bench sees this as samples that should have been dropped reaching `dac_data`.

// File: rtl/sgate_pkg.sv
`timescale 1ns/1ps
package sgate_pkg;
  // Action taken by the gate controller in one internal-domain cycle.
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_MOVE = 2'd1,
    GATE_DROP = 2'd2
  } gate_act_e;
endpackage

// File: rtl/sgate_s1_fifo.sv
`timescale 1ns/1ps
module sgate_s1_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic [W-1:0] out_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          push;

  assign in_ready = (count != CW'(DEPTH));
  assign push     = in_valid && in_ready;
  assign empty    = (count == '0);
  assign out_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never exceeds the configured depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6: the controller never pops a lane that holds nothing
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sgate_cdc_fifo.sv
`timescale 1ns/1ps
module sgate_cdc_fifo #(
  parameter int W          = 8,
  parameter int DEPTH      = 4,
  parameter int FILL_LIMIT = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_room,
  output logic         ufl_pulse,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];

  // write side (internal domain)
  logic [PW-1:0] wbin, wgray, wbin_nx;
  logic [PW-1:0] rg_s1, rg_s2;
  logic [PW-1:0] fill;
  logic          u_s1, u_s2, u_s3;

  assign wbin_nx   = wbin + PW'(1);
  assign fill      = wbin - gray2bin(rg_s2);
  assign wr_room   = (fill < PW'(FILL_LIMIT));
  assign ufl_pulse = u_s2 ^ u_s3;

  always_ff @(posedge wclk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      u_s1  <= 1'b0;
      u_s2  <= 1'b0;
      u_s3  <= 1'b0;
    end else begin
      if (wr_en) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      u_s1  <= ufl_tgl;
      u_s2  <= u_s1;
      u_s3  <= u_s2;
    end
  end

  // read side (converter domain)
  logic [PW-1:0] rbin, rgray, rbin_nx;
  logic [PW-1:0] wg_s1, wg_s2;
  logic          empty_r;
  logic          ufl_tgl;

  assign rbin_nx = rbin + PW'(1);
  assign empty_r = (rgray == wg_s2);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      rd_data <= '0;
      ufl_tgl <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_en) begin
        if (!empty_r) begin
          rd_data <= mem[rbin[AW-1:0]];
          rbin    <= rbin_nx;
          rgray   <= rbin_nx ^ (rbin_nx >> 1);
        end else begin
          rd_data <= '0;
          ufl_tgl <= ~ufl_tgl;
        end
      end
    end
  end

  // R4: the gate writes only while the seen occupancy is under the limit
  a_r4_write_below_limit: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_en |-> (fill < PW'(FILL_LIMIT)));
  // R4: the seen occupancy never climbs past the limit
  a_r4_fill_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
    fill <= PW'(FILL_LIMIT));
  // R7: a read on an empty stage presents zero
  a_r7_zero_on_underrun: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty_r) |=> (rd_data == '0));
endmodule

// File: rtl/sgate_quota.sv
`timescale 1ns/1ps
module sgate_quota
  import sgate_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int QUOTA  = 4,
  parameter int BACKUP = 1,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LANES-1:0] s1_empty,
  input  logic [LANES-1:0] s2_room,
  output logic             move,
  output logic             drop,
  output logic [CNT_W-1:0] drop_count
);
  localparam int LW  = $clog2(QUOTA + BACKUP + 1);
  localparam int DW  = LW + 4;
  localparam logic [LW-1:0] QUOTA_C  = LW'(QUOTA);
  localparam logic [LW-1:0] BACKUP_C = LW'(BACKUP);

  logic [LW-1:0] left_q;
  logic [DW-1:0] owe_q;
  logic          boot_q;
  logic          all_have, all_room;
  gate_act_e     act;

  assign all_have = ~|s1_empty;
  assign all_room = &s2_room;

  always_comb begin
    act = GATE_IDLE;
    if (!trig) begin
      if (owe_q != '0 && all_have)
        act = GATE_DROP;
      else if (owe_q == '0 && left_q != '0 && all_have && all_room)
        act = GATE_MOVE;
    end
  end

  assign move = (act == GATE_MOVE);
  assign drop = (act == GATE_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q     <= BACKUP_C;
      owe_q      <= '0;
      boot_q     <= 1'b1;
      drop_count <= '0;
    end else if (trig) begin
      boot_q <= 1'b0;
      if (boot_q) begin
        left_q <= left_q + QUOTA_C;
      end else begin
        left_q <= QUOTA_C;
        owe_q  <= owe_q + DW'(left_q);
      end
    end else begin
      case (act)
        GATE_MOVE: left_q <= left_q - LW'(1);
        GATE_DROP: begin
          owe_q      <= owe_q - DW'(1);
          drop_count <= drop_count + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R5: a trigger after start-up reloads a full quota
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !boot_q) |=> (left_q == QUOTA_C));
  // R3: a cycle either moves or drops, never both
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({move, drop}));
  // R2: nothing is owed for dropping before the first trigger
  a_r2_boot_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |-> (owe_q == '0));
  // R3: each move consumes exactly one unit of quota
  a_r3_move_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> (left_q == $past(left_q) - LW'(1)));
  // R5: each drop advances the drop counter by one
  a_r5_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (drop_count == $past(drop_count) + CNT_W'(1)));
endmodule

// File: rtl/dual_stage_gate.sv
`timescale 1ns/1ps
module dual_stage_gate #(
  parameter int LANES      = 2,
  parameter int W          = 8,
  parameter int S1_DEPTH   = 32,
  parameter int S2_DEPTH   = 4,
  parameter int FILL_LIMIT = 2,
  parameter int QUOTA      = 4,
  parameter int BACKUP     = 1,
  parameter int CNT_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   in_valid,
  output logic [LANES-1:0]   in_ready,
  input  logic [LANES*W-1:0] in_data,
  input  logic               trig,
  output logic [CNT_W-1:0]   drop_count,
  output logic [LANES-1:0]   underrun,
  input  logic               dac_clk,
  input  logic               dac_rst_n,
  input  logic [LANES-1:0]   dac_rd,
  output logic [LANES*W-1:0] dac_data
);
  logic [LANES-1:0] s1_empty;
  logic [LANES-1:0] s2_room;
  logic             move, drop;

  sgate_quota #(
    .LANES (LANES),
    .QUOTA (QUOTA),
    .BACKUP(BACKUP),
    .CNT_W (CNT_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .s1_empty  (s1_empty),
    .s2_room   (s2_room),
    .move      (move),
    .drop      (drop),
    .drop_count(drop_count)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] head;

    sgate_s1_fifo #(
      .W    (W),
      .DEPTH(S1_DEPTH)
    ) u_s1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid[l]),
      .in_ready(in_ready[l]),
      .in_data (in_data[l*W +: W]),
      .pop     (move | drop),
      .out_data(head),
      .empty   (s1_empty[l])
    );

    sgate_cdc_fifo #(
      .W         (W),
      .DEPTH     (S2_DEPTH),
      .FILL_LIMIT(FILL_LIMIT)
    ) u_s2 (
      .wclk     (clk),
      .wrst_n   (rst_n),
      .wr_en    (move),
      .wr_data  (head),
      .wr_room  (s2_room[l]),
      .ufl_pulse(underrun[l]),
      .rclk     (dac_clk),
      .rrst_n   (dac_rst_n),
      .rd_en    (dac_rd[l]),
      .rd_data  (dac_data[l*W +: W])
    );
  end

  // R5: the drop counter never moves backwards
  a_r5_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> (drop_count == $past(drop_count)));
  // R7: an underrun pulse never lasts two cycles on any lane
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun != '0) |=> ((underrun & $past(underrun)) == '0));
endmodule

// File: tb/tb_dual_stage_gate.sv
`timescale 1ns/1ps
module tb_dual_stage_gate;
  localparam int LANES = 2;
  localparam int W     = 8;
  localparam int CNT_W = 16;

  logic               clk = 1'b0, dac_clk = 1'b0;
  logic               rst_n = 1'b0, dac_rst_n = 1'b0;
  logic [LANES-1:0]   in_valid = '0;
  logic [LANES-1:0]   in_ready;
  logic [LANES*W-1:0] in_data = '0;
  logic               trig = 1'b0;
  logic [CNT_W-1:0]   drop_count;
  logic [LANES-1:0]   underrun;
  logic [LANES-1:0]   dac_rd = '0;
  logic [LANES*W-1:0] dac_data;

  int checks = 0, errors = 0;
  int ucnt [LANES];
  int next_k = 0;

  always #2.5 clk = ~clk;
  always #3.5 dac_clk = ~dac_clk;

  dual_stage_gate dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .trig(trig), .drop_count(drop_count),
    .underrun(underrun), .dac_clk(dac_clk), .dac_rst_n(dac_rst_n),
    .dac_rd(dac_rd), .dac_data(dac_data)
  );

  initial for (int l = 0; l < LANES; l++) ucnt[l] = 0;
  always @(posedge clk)
    for (int l = 0; l < LANES; l++) if (underrun[l]) ucnt[l] <= ucnt[l] + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_one();
    @(negedge clk);
    while (!(&in_ready)) @(negedge clk);
    in_valid = '1;
    for (int l = 0; l < LANES; l++) in_data[l*W +: W] = W'(l*64 + next_k);
    @(negedge clk);
    in_valid = '0;
    next_k++;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  // one read on every lane; k < 0 means an empty read is expected
  task automatic read_expect(input string req, input int k);
    @(negedge dac_clk); dac_rd = '1;
    @(negedge dac_clk); dac_rd = '0;
    for (int l = 0; l < LANES; l++)
      check(req, int'(dac_data[l*W +: W]), (k < 0) ? 0 : (l*64 + k));
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; dac_rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 in_ready", int'(in_ready), 3);
    check("R8 dac_data", int'(dac_data), 0);
    check("R8 drop_count", int'(drop_count), 0);
    check("R8 underrun", ucnt[0] + ucnt[1], 0);

    for (int i = 0; i < 24; i++) push_one();
    repeat (30) @(negedge clk);
    check("R1 ready below depth", int'(in_ready), 3);
    // R2 only the backup sample crossed before any trigger
    read_expect("R2 backup", 0);
    read_expect("R2 no more before trigger", -1);
    for (int l = 0; l < LANES; l++) check("R7 underrun pulse", ucnt[l], 1);

    // R3 first trigger: exact quota, in order
    pulse_trig();
    for (int k = 1; k <= 4; k++) read_expect("R3 quota sample", k);
    read_expect("R3 quota exhausted", -1);
    for (int l = 0; l < LANES; l++) check("R7 underrun count", ucnt[l], 2);
    check("R5 no drop after full quota", int'(drop_count), 0);

    // R4/R5 two triggers with no reads: two cross, two are dropped
    pulse_trig();
    pulse_trig();
    check("R5 drop_count", int'(drop_count), 2);
    read_expect("R4 limited fill", 5);
    read_expect("R4 limited fill", 6);
    for (int k = 9; k <= 12; k++) read_expect("R5 after drop", k);
    read_expect("R5 quota exhausted", -1);
    for (int l = 0; l < LANES; l++) check("R7 underrun count", ucnt[l], 3);

    // R6 complete quota, no drop, order continues
    pulse_trig();
    for (int k = 13; k <= 16; k++) read_expect("R6 order", k);
    check("R5 drop unchanged", int'(drop_count), 2);

    // R1 fill the first stage: 7 left, 25 more reach the depth of 32
    for (int i = 0; i < 25; i++) push_one();
    repeat (4) @(negedge clk);
    check("R1 ready low when full", int'(in_ready), 0);
    pulse_trig();
    for (int k = 17; k <= 20; k++) read_expect("R6 order after full", k);
    check("R1 ready back", int'(in_ready), 3);
    check("R5 drop final", int'(drop_count), 2);
    for (int l = 0; l < LANES; l++) check("R7 no spurious underrun", ucnt[l], 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule